// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns one request from a simple valid/ready interface into the strobe waveform of a single asynchronous NAND flash bus cycle. A request is a command byte, an address byte, a data read or a data write. The block drives chip enable, the command latch and address latch enables, the read and write strobes, and a data bus that is split into an output value, an output enable and an input value. The block keeps the pins idle until a bank-enable bit in its configuration is set.

Each access moves through a setup phase, a strobe phase and a hold phase, and each phase lasts a programmable number of clock cycles. Command and address cycles take their counts from one timing word, and data reads and writes take theirs from another. The data bus output enable on a write-type access is delayed by a programmable high-impedance count. A read that directly follows a command or an address cycle is preceded by a programmable latch-to-read gap. When the stall option is set, a low ready/busy input stretches the strobe phase. A one-cycle done pulse marks the last hold cycle, and read data is returned on a separate output.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, both timing words are 0x0A0A0A0A, both latch-to-read gap fields are 0xF, the bank is disabled, the stall option is off and the data width is 8 bits. Every pin is idle: chip enable and both strobes are high, both latch enables are low and the output enable is low.
- R2: An accepted access starts on the next cycle with setup, then strobe, then hold. Chip enable is low through all three phases. The write strobe (for kinds 0, 1 and 3) or the read strobe (kind 2) is low only during the strobe phase, for exactly the wait count in cycles. Kinds: 0 command, 1 address, 2 read, 3 write.
- R3: A setup, wait or hold field of zero lasts one cycle. Timing word layout: setup in bits 7:0, wait in bits 15:8, hold in bits 23:16 and high-impedance count in bits 31:24.
- R4: While the bank-enable bit is clear, req_ready stays low, requests are ignored and chip enable stays high.
- R5: Command and address accesses use the timing word written with cfg_sel 1. Reads and writes use the word written with cfg_sel 0. The control word is written with cfg_sel 2.
- R6: A command access holds the command latch enable high, and an address access holds the address latch enable high, through setup, strobe and hold. Both access kinds place their byte on bus bits 7:0 with the upper bits at zero.
- R7: With the stall option on (control bit 1), the strobe phase does not end while ready/busy is low on its final cycle. With the option off, ready/busy has no effect.
- R8: On kinds 0, 1 and 3, the output enable rises at cycle hiz+1 counted from the first setup cycle (cycle 0), and it stays high until the end of hold. If that cycle falls after hold, the output enable never rises. The output enable is never high on a read.
- R9: Read data is captured on the last strobe cycle. With the 16-bit width selected it is the full bus value; with the 8-bit width it is the low byte zero-extended.
- R10: A read accepted directly after a command access first spends (control bits 7:4)+1 cycles with chip enable low and all strobes idle. After an address access the gap is (control bits 11:8)+1 cycles. No other read has this gap.
- R11: done is high for exactly one cycle, on the last hold cycle. req_ready is low from the first cycle of an access until that pulse.
- R12: The data width (control bit 2, 1 = 16 bits) is sampled when a request is accepted, so it can change between accesses. A 16-bit write drives the full word, and an 8-bit write drives the low byte with the upper bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select: 0 data timing, 1 command/address timing, 2 control |
| cfg_wdata | input | 32 | Configuration word value |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind: 0 command, 1 address, 2 read, 3 write |
| req_wdata | input | DQ_W | Byte or data word to drive |
| req_ready | output | 1 | Idle and bank enabled; request taken when both valid and ready |
| done | output | 1 | One-cycle pulse on the last hold cycle |
| rd_data | output | DQ_W | Data captured by the last read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq_o | output | DQ_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | DQ_W | Data bus input value |
| nand_rb_n | input | 1 | Ready/busy, low while the device is busy |

## Verification
Two events can fall in the same cycle: the strobe counter reaching its last cycle and the ready/busy release. The bench holds ready/busy low and then releases it at a chosen cycle offset from the start of the access. In one run the release comes long after the wait count expires, and in another it comes before the last strobe cycle. The expected strobe length is taken as the later of the two ends, and the same release pattern with stalling disabled must leave the strobe at its programmed length.

// File: rtl/nbs_pkg.sv
// Shared types for the NAND bus cycle sequencer.
// Assumes: timing fields are 8 bits and latch-to-read gaps are 4 bits wide.
package nbs_pkg;
    localparam int FIELD_W = 8;
    localparam int GAP_W   = 4;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_READ  = 2'd2,
        KIND_WRITE = 2'd3
    } nbs_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } nbs_phase_e;

    // Packed MSB first so that setup lands in bits 7:0 of the word.
    typedef struct packed {
        logic [FIELD_W-1:0] hiz;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] strobe;
        logic [FIELD_W-1:0] setup;
    } nbs_timing_t;

    typedef struct packed {
        logic [GAP_W-1:0] ale_gap;
        logic [GAP_W-1:0] cle_gap;
        logic             wide;
        logic             rb_stall;
        logic             bank_on;
    } nbs_ctrl_t;

    localparam logic [1:0] SEL_DATA_TIM = 2'd0;
    localparam logic [1:0] SEL_CA_TIM   = 2'd1;
    localparam logic [1:0] SEL_CTRL     = 2'd2;
endpackage

// File: rtl/nbs_cfg.sv
// Configuration store: two timing words and one control word.
// Assumes: software writes a whole word at a time, and only while idle.
module nbs_cfg
    import nbs_pkg::*;
#(
    parameter logic [31:0]      TIMING_RESET = 32'h0A0A_0A0A,
    parameter logic [GAP_W-1:0] GAP_RESET    = 4'hF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output nbs_timing_t data_tim,
    output nbs_timing_t ca_tim,
    output nbs_ctrl_t   ctrl
);

    // Load the selected word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_tim <= nbs_timing_t'(TIMING_RESET);
            ca_tim   <= nbs_timing_t'(TIMING_RESET);
            ctrl     <= '{ale_gap: GAP_RESET, cle_gap: GAP_RESET,
                          wide: 1'b0, rb_stall: 1'b0, bank_on: 1'b0};
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_DATA_TIM: data_tim <= nbs_timing_t'(cfg_wdata);
                SEL_CA_TIM:   ca_tim   <= nbs_timing_t'(cfg_wdata);
                SEL_CTRL:     ctrl     <= '{ale_gap:  cfg_wdata[11:8],
                                            cle_gap:  cfg_wdata[7:4],
                                            wide:     cfg_wdata[2],
                                            rb_stall: cfg_wdata[1],
                                            bank_on:  cfg_wdata[0]};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nbs_seq.sv
// Phase sequencer: optional gap, then setup, strobe and hold, each counted down.
// Assumes: start is only raised in PH_IDLE; a zero field means one cycle.
module nbs_seq
    import nbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  nbs_timing_t        tim_in,
    input  logic               gap_en,
    input  logic [GAP_W-1:0]   gap_len,
    input  logic               rb_n,
    input  logic               stall_en,
    output nbs_phase_e         phase,
    output logic [FIELD_W-1:0] hiz_q,
    output logic               strobe_end,
    output logic               access_end
);

    nbs_timing_t        tim_q;
    logic [FIELD_W-1:0] cnt;
    logic               cnt_zero;

    // Remaining-cycle load value for a field: zero and one both give one cycle.
    function automatic logic [FIELD_W-1:0] span(input logic [FIELD_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign cnt_zero   = (cnt == '0);
    assign strobe_end = (phase == PH_STROBE) && cnt_zero && !(stall_en && !rb_n);
    assign access_end = (phase == PH_HOLD) && cnt_zero;
    assign hiz_q      = tim_q.hiz;

    // Advance through the phases and count each one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tim_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        tim_q <= tim_in;
                        if (gap_en) begin
                            phase <= PH_GAP;
                            cnt   <= {{(FIELD_W-GAP_W){1'b0}}, gap_len};
                        end else begin
                            phase <= PH_SETUP;
                            cnt   <= span(tim_in.setup);
                        end
                    end
                end
                PH_GAP: begin
                    if (cnt_zero) begin
                        phase <= PH_SETUP;
                        cnt   <= span(tim_q.setup);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_STROBE;
                        cnt   <= span(tim_q.strobe);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (strobe_end) begin
                        phase <= PH_HOLD;
                        cnt   <= span(tim_q.hold);
                    end else if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nbs_pins.sv
// Pin stage: decodes strobes from the phase, times the bus output enable,
// and captures read data.
// Assumes: at least one idle cycle separates two accesses, which clears the
// elapsed counter.
module nbs_pins
    import nbs_pkg::*;
#(
    parameter int DQ_W      = 16,
    parameter int ELAPSED_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  nbs_phase_e         phase,
    input  nbs_kind_e          kind_q,
    input  logic [DQ_W-1:0]    wdata_q,
    input  logic [FIELD_W-1:0] hiz,
    input  logic               wide_q,
    input  logic               strobe_end,
    input  logic [DQ_W-1:0]    dq_i,
    output logic               ce_n,
    output logic               cle,
    output logic               ale,
    output logic               re_n,
    output logic               we_n,
    output logic [DQ_W-1:0]    dq_o,
    output logic               dq_oe,
    output logic [DQ_W-1:0]    rd_data
);

    localparam int                   BYTE_W      = DQ_W / 2;
    localparam logic [ELAPSED_W-1:0] ELAPSED_MAX = '1;

    logic                 framed;
    logic                 drives_bus;
    logic [ELAPSED_W-1:0] elapsed;
    logic [ELAPSED_W-1:0] oe_at;

    assign framed     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign drives_bus = (kind_q != KIND_READ);
    assign oe_at      = {{(ELAPSED_W-FIELD_W){1'b0}}, hiz} + 1'b1;

    assign ce_n  = (phase == PH_IDLE);
    assign cle   = framed && (kind_q == KIND_CMD);
    assign ale   = framed && (kind_q == KIND_ADDR);
    assign we_n  = !((phase == PH_STROBE) && drives_bus);
    assign re_n  = !((phase == PH_STROBE) && !drives_bus);
    assign dq_o  = wdata_q;
    assign dq_oe = framed && drives_bus && (elapsed >= oe_at);

    // Count cycles since the first setup cycle, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || !framed) begin
            elapsed <= '0;
        end else if (elapsed != ELAPSED_MAX) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Capture the bus on the final strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (strobe_end && !drives_bus) begin
            rd_data <= wide_q ? dq_i : {{(DQ_W-BYTE_W){1'b0}}, dq_i[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/nand_cycle_seq.sv
// Top of the NAND bus cycle sequencer: accepts one request, picks its timing
// word and any gap, and drives one bus access through nbs_seq and nbs_pins.
// Assumes: configuration is rewritten only between accesses.
module nand_cycle_seq
    import nbs_pkg::*;
#(
    parameter int               DQ_W         = 16,
    parameter int               ELAPSED_W    = 10,
    parameter logic [31:0]      TIMING_RESET = 32'h0A0A_0A0A,
    parameter logic [GAP_W-1:0] GAP_RESET    = 4'hF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [DQ_W-1:0] req_wdata,
    output logic            req_ready,
    output logic            done,
    output logic [DQ_W-1:0] rd_data,
    output logic            nand_ce_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic            nand_re_n,
    output logic            nand_we_n,
    output logic [DQ_W-1:0] nand_dq_o,
    output logic            nand_dq_oe,
    input  logic [DQ_W-1:0] nand_dq_i,
    input  logic            nand_rb_n
);

    localparam int BYTE_W = DQ_W / 2;

    nbs_timing_t        data_tim;
    nbs_timing_t        ca_tim;
    nbs_timing_t        sel_tim;
    nbs_ctrl_t          ctrl;
    nbs_kind_e          kind_in;
    nbs_kind_e          kind_q;
    nbs_phase_e         phase;
    logic [DQ_W-1:0]    wdata_q;
    logic [DQ_W-1:0]    wdata_shaped;
    logic               wide_q;
    logic               prev_cmd;
    logic               prev_addr;
    logic               start;
    logic               gap_en;
    logic [GAP_W-1:0]   gap_len;
    logic [FIELD_W-1:0] hiz_q;
    logic               strobe_end;
    logic               access_end;
    logic               rb_stall_en;
    logic               is_data;

    assign kind_in     = nbs_kind_e'(req_kind);
    assign is_data     = (kind_in == KIND_READ) || (kind_in == KIND_WRITE);
    assign req_ready   = (phase == PH_IDLE) && ctrl.bank_on;
    assign start       = req_ready && req_valid;
    assign sel_tim     = is_data ? data_tim : ca_tim;
    assign gap_en      = (kind_in == KIND_READ) && (prev_cmd || prev_addr);
    assign gap_len     = prev_cmd ? ctrl.cle_gap : ctrl.ale_gap;
    assign done        = access_end;
    assign rb_stall_en = ctrl.rb_stall;

    // Narrow everything except a wide data write down to the low byte.
    assign wdata_shaped = (is_data && ctrl.wide) ? req_wdata
                        : {{(DQ_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};

    // Latch the request and remember whether it was a latch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= KIND_CMD;
            wdata_q   <= '0;
            wide_q    <= 1'b0;
            prev_cmd  <= 1'b0;
            prev_addr <= 1'b0;
        end else if (start) begin
            kind_q    <= kind_in;
            wdata_q   <= wdata_shaped;
            wide_q    <= ctrl.wide;
            prev_cmd  <= (kind_in == KIND_CMD);
            prev_addr <= (kind_in == KIND_ADDR);
        end
    end

    nbs_cfg #(
        .TIMING_RESET (TIMING_RESET),
        .GAP_RESET    (GAP_RESET)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .data_tim  (data_tim),
        .ca_tim    (ca_tim),
        .ctrl      (ctrl)
    );

    nbs_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tim_in     (sel_tim),
        .gap_en     (gap_en),
        .gap_len    (gap_len),
        .rb_n       (nand_rb_n),
        .stall_en   (ctrl.rb_stall),
        .phase      (phase),
        .hiz_q      (hiz_q),
        .strobe_end (strobe_end),
        .access_end (access_end)
    );

    nbs_pins #(
        .DQ_W      (DQ_W),
        .ELAPSED_W (ELAPSED_W)
    ) i_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .kind_q     (kind_q),
        .wdata_q    (wdata_q),
        .hiz        (hiz_q),
        .wide_q     (wide_q),
        .strobe_end (strobe_end),
        .dq_i       (nand_dq_i),
        .ce_n       (nand_ce_n),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .re_n       (nand_re_n),
        .we_n       (nand_we_n),
        .dq_o       (nand_dq_o),
        .dq_oe      (nand_dq_oe),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/nbs_checker.sv
// Pin-level protocol checks for nand_cycle_seq, attached by bind.
// Assumes: the stall option is not rewritten during an access.
module nbs_checker (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic re_n,
    input logic we_n,
    input logic dq_oe,
    input logic done,
    input logic rb_n,
    input logic rb_stall
);

    // R2: never both strobes at once.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!re_n && !we_n));

    // R2: a strobe only inside a chip-enabled access.
    a_r2_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n || !we_n) |-> !ce_n);

    // R6: the two latch enables never overlap.
    a_r6_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R7: while stalling on busy, the strobe is still low on the next cycle.
    a_r7_busy_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((!re_n || !we_n) && rb_stall && !rb_n) |=> (!re_n || !we_n));

    // R8: the bus is only driven inside an access and never with the read strobe.
    a_r8_oe_not_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && re_n));

    // R11: done lasts one cycle.
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done comes in a hold cycle, with strobes released, and ends the access.
    a_r11_done_ends_access: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ce_n && re_n && we_n) ##1 ce_n);
endmodule

bind nand_cycle_seq nbs_checker i_nbs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .re_n     (nand_re_n),
    .we_n     (nand_we_n),
    .dq_oe    (nand_dq_oe),
    .done     (done),
    .rb_n     (nand_rb_n),
    .rb_stall (rb_stall_en)
);

// File: tb/test_nand_cycle_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each access's pin profile and queues it;
// the monitor measures the pins and compares when done pulses.
module test_nand_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_re_n, nand_we_n, nand_dq_oe;
    logic [15:0] nand_dq_o;
    logic [15:0] nand_dq_i = 16'hC3A5;
    logic        nand_rb_n = 1'b1;

    always #2.5 clk = ~clk;

    nand_cycle_seq i_nand_cycle_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    typedef struct {
        int          kind;
        int          lead;
        int          strobe;
        int          tail;
        int          oe_first;
        int          oe_cnt;
        int          cle_cnt;
        int          ale_cnt;
        logic [15:0] bus;
        logic [15:0] rdat;
    } exp_t;

    exp_t scb[$];
    int   n_checks = 0;
    int   n_fail = 0;

    // Bench-side copy of the configuration it has written.
    logic [31:0] m_data = 32'h0A0A0A0A;
    logic [31:0] m_ca   = 32'h0A0A0A0A;
    bit          m_stall = 1'b0;
    bit          m_wide  = 1'b0;
    int          m_cle_gap = 15;
    int          m_ale_gap = 15;
    int          m_prev = -1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_data = w;
            2'd1: m_ca = w;
            default: begin
                m_stall = w[1]; m_wide = w[2];
                m_cle_gap = int'(w[7:4]); m_ale_gap = int'(w[11:8]);
            end
        endcase
    endtask

    // Driver: build the expected profile, queue it, run the handshake.
    // rel >= 0 holds ready/busy low until that cycle of the access.
    task automatic access(input int kind, input logic [15:0] d, input int rel);
        exp_t e;
        logic [31:0] t;
        int s, w, h, z, gap, wa, k, span;
        t = (kind >= 2) ? m_data : m_ca;
        s = eff(t[7:0]); w = eff(t[15:8]); h = eff(t[23:16]); z = int'(t[31:24]);
        gap = 0;
        if (kind == 2 && m_prev == 0) gap = m_cle_gap + 1;
        if (kind == 2 && m_prev == 1) gap = m_ale_gap + 1;
        wa = w;
        if (rel >= 0 && m_stall) begin
            k = gap + s + w - 1;
            if (rel > k) k = rel;
            wa = k - (gap + s) + 1;
        end
        span = s + wa + h;
        e.kind = kind; e.lead = gap + s; e.strobe = wa; e.tail = h;
        e.oe_first = -1; e.oe_cnt = 0;
        if (kind != 2 && (z + 1) < span) begin
            e.oe_first = z + 1; e.oe_cnt = span - z - 1;
        end
        e.cle_cnt = (kind == 0) ? span : 0;
        e.ale_cnt = (kind == 1) ? span : 0;
        e.bus = (kind == 3 && m_wide) ? d : {8'h00, d[7:0]};
        e.rdat = m_wide ? nand_dq_i : {8'h00, nand_dq_i[7:0]};
        m_prev = kind;
        scb.push_back(e);
        if (rel >= 0) nand_rb_n = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = kind[1:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (rel >= 0) begin
            repeat (rel) @(negedge clk);
            nand_rb_n = 1'b1;
        end
        while (scb.size() != 0) @(negedge clk);
    endtask

    // Monitor: measure each access at the pins, compare on done.
    bit          act = 1'b0;
    bit          rdy_seen;
    int          mi, mo_lead, mo_str, mo_tail, mo_oef, mo_oec, mo_cle, mo_ale;
    logic [15:0] mo_bus;
    exp_t        me;

    always @(negedge clk) begin
        if (rst_n && !nand_ce_n) begin
            if (!act) begin
                act = 1'b1; mi = 0; mo_lead = -1; mo_str = 0; mo_tail = 0;
                mo_oef = -1; mo_oec = 0; mo_cle = 0; mo_ale = 0; mo_bus = '0;
                rdy_seen = 1'b0;
            end
            if (req_ready) rdy_seen = 1'b1;
            if (!nand_re_n || !nand_we_n) begin
                if (mo_str == 0) begin mo_lead = mi; mo_bus = nand_dq_o; end
                mo_str++;
            end else if (mo_str > 0) begin
                mo_tail++;
            end
            if (nand_dq_oe) begin
                if (mo_oef < 0) mo_oef = mi;
                mo_oec++;
            end
            if (nand_cle) mo_cle++;
            if (nand_ale) mo_ale++;
            if (done) begin
                if (scb.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    me = scb.pop_front();
                    check(mo_lead == me.lead, "R10", "cycles before strobe", mo_lead, me.lead);
                    check(mo_str == me.strobe, "R7", "strobe length", mo_str, me.strobe);
                    check(mo_tail == me.tail, "R2", "hold length", mo_tail, me.tail);
                    check(mo_oef == me.oe_first, "R8", "oe first cycle", mo_oef, me.oe_first);
                    check(mo_oec == me.oe_cnt, "R8", "oe cycles", mo_oec, me.oe_cnt);
                    check(mo_cle == me.cle_cnt, "R6", "cle cycles", mo_cle, me.cle_cnt);
                    check(mo_ale == me.ale_cnt, "R6", "ale cycles", mo_ale, me.ale_cnt);
                    check(!rdy_seen, "R11", "ready during access", int'(rdy_seen), 0);
                    if (me.kind == 2)
                        check(rd_data == me.rdat, "R9", "read data", int'(rd_data), int'(me.rdat));
                    else
                        check(mo_bus == me.bus, "R12", "bus value", int'(mo_bus), int'(me.bus));
                end
                act = 1'b0;
            end
            mi++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit quiet;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pins and bank disabled after reset
        check(nand_ce_n && nand_re_n && nand_we_n, "R1", "strobes idle",
              int'({nand_ce_n, nand_re_n, nand_we_n}), 7);
        check(!nand_cle && !nand_ale && !nand_dq_oe && !done, "R1", "enables idle",
              int'({nand_cle, nand_ale, nand_dq_oe, done}), 0);
        check(!req_ready, "R1", "ready with bank off", int'(req_ready), 0);

        // R4: requests ignored while the bank is disabled
        req_valid = 1'b1; req_kind = 2'd0; req_wdata = 16'h00FF;
        quiet = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!nand_ce_n || req_ready) quiet = 1'b0;
        end
        req_valid = 1'b0;
        check(quiet, "R4", "pins quiet with bank off", int'(quiet), 1);

        // R1: default 10-cycle timing, R6 command latch
        cfg_write(2'd2, 32'h0000_0FF1);
        access(0, 16'h0070, -1);
        // R10: default command gap of 16 before a read, R9 8-bit read
        access(2, 16'h0000, -1);

        // R3: zero fields in the command/address set; R5 separate sets
        cfg_write(2'd1, 32'h0000_0000);
        cfg_write(2'd0, 32'h0203_0405);
        cfg_write(2'd2, 32'h0000_0365);
        access(1, 16'hAB12, -1);   // R6 address, R3 one-cycle phases
        access(2, 16'h0000, -1);   // R10 address gap, R9/R12 wide read
        access(0, 16'h0090, -1);   // R5 command ignores data set
        access(2, 16'h0000, -1);   // R10 command gap 7
        access(2, 16'h0000, -1);   // R10 no gap after a read
        access(3, 16'hBEEF, -1);   // R12 wide write, R8 oe from cycle 3

        cfg_write(2'd2, 32'h0000_0361);
        access(3, 16'hBEEF, -1);   // R12 narrow write drives low byte only

        cfg_write(2'd0, 32'h2001_0101);
        access(3, 16'h1234, -1);   // R8 oe never rises when hiz is too long

        // R7: stall on busy
        cfg_write(2'd0, 32'h0001_0202);
        cfg_write(2'd2, 32'h0000_0363);
        access(3, 16'h5555, 9);    // R7 released long after wait expires
        access(3, 16'h6666, 1);    // R7 released before the last strobe cycle
        access(0, 16'h00AA, 5);    // R7 stall on a command strobe
        cfg_write(2'd2, 32'h0000_0361);
        access(3, 16'h7777, 9);    // R7 busy ignored with stall off

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule